// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the 13-bit instruction fetch address for a small 8-bit processor. The address has two parts: a 3-bit page register and a 10-bit offset inside the page. The decoder sends one operation code per cycle. The code asks the block to advance, to branch within the page, to enter or leave a subroutine, to take an interrupt, or to return from one. The block keeps an 8-level return stack of offsets and a one-level shadow of the accumulator, status and page values. The shadow is filled when an interrupt is taken and handed back on the interrupt return.

To reach another page, software writes the page register first. A later branch then loads only the offset. Any operation that redirects the flow raises a stall for the following cycle, so the fetch takes a second cycle. During that cycle every input is ignored. Return-with-literal uses the plain return code, because the literal is handled by the datapath.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the fetch address is 0, the stall output is 0, ctx_valid is 0 and every return stack slot holds offset 0.
- R2: The fetch address is {page, offset}. Code 1 (STEP) adds one to the offset. The offset wraps from 0x3FF to 0x000 and the page stays unchanged.
- R3: Code 2 (JUMP) loads the offset from the target input and leaves the page unchanged. A page write (page_we with page_wd) takes effect on the same clock edge as the operation it arrives with, for codes 0 to 4.
- R4: Code 3 (CALL) pushes the current offset plus one, wrapped to 10 bits, and loads the offset from the target input.
- R5: Code 4 (RET) loads the offset from the top of the stack and pops it, leaving the page unchanged. Eight nested calls return in last-in first-out order.
- R6: The stack pointer wraps modulo 8. A ninth push overwrites the oldest entry. A pop from an empty stack reads the slot below the pointer with wrap-around. Neither case is reported.
- R7: Codes 2 to 6 raise stall for exactly the one cycle after they are taken. Codes 0, 1 and 7 never raise it.
- R8: While stall is high, the operation code and the page write are ignored and the fetch address holds.
- R9: Code 6 (IRQ) pushes the current offset and loads the offset from the vector table entry of irq_src: sources 0 to 3 map to 0x006, 0x008, 0x00A and 0x00C. It forces the page to 0 and saves acc_in, stat_in and the current page. A page write that arrives with it is dropped.
- R10: Code 5 (RETI) pops the stack into the offset and restores the saved page. In the next cycle it pulses ctx_valid for one cycle, with ctx_acc and ctx_stat carrying the saved values. A page write that arrives with it is dropped.
- R11: Codes 0 (HOLD) and 7 (reserved) leave the fetch address unchanged, apart from any page write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation code (0 HOLD, 1 STEP, 2 JUMP, 3 CALL, 4 RET, 5 RETI, 6 IRQ, 7 reserved) |
| target | input | 10 | Offset field for JUMP and CALL |
| irq_src | input | 2 | Interrupt source index used by IRQ |
| page_we | input | 1 | Page register write strobe |
| page_wd | input | 3 | Page register write data |
| acc_in | input | 8 | Accumulator value saved on IRQ |
| stat_in | input | 8 | Status value saved on IRQ |
| fetch_addr | output | 13 | Instruction fetch address {page, offset} |
| stall | output | 1 | Second-cycle request after a flow change |
| ctx_acc | output | 8 | Saved accumulator value |
| ctx_stat | output | 8 | Saved status value |
| ctx_valid | output | 1 | One-cycle pulse when the saved context is handed back |

## Verification
The assertions run on every cycle and cover the local rules:
- STEP increments the offset, JUMP loads it, and both keep the page.
- Stall lasts exactly one cycle, follows every flow change, and freezes the address while it is high.
- IRQ lands in page 0.
- HOLD keeps the address.
- ctx_valid is tied to a taken RETI.

Some behaviours depend on what earlier cycles stored, so only the bench's scenarios can show them. These are:
- the last-in first-out order of eight nested calls;
- the wrap of the stack pointer on overflow and on underflow;
- the value a pop from an empty stack returns;
- a page change made before a jump;
- the page and context values brought back by an interrupt return.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
   typedef enum logic [2:0] {
      OP_HOLD = 3'd0,
      OP_STEP = 3'd1,
      OP_JUMP = 3'd2,
      OP_CALL = 3'd3,
      OP_RET  = 3'd4,
      OP_RETI = 3'd5,
      OP_IRQ  = 3'd6,
      OP_RSVD = 3'd7
   } pc_op_e;
endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
   parameter int W     = 10,
   parameter int DEPTH = 8,
   parameter bit CLEAR = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] top
);
   localparam int PW = $clog2(DEPTH);

   logic [PW-1:0] ptr;
   logic [PW-1:0] rd_idx;
   logic [W-1:0]  mem [DEPTH];

   assign rd_idx = ptr - PW'(1);
   assign top    = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (push) ptr <= ptr + PW'(1);
      else if (pop)  ptr <= rd_idx;
   end

   if (CLEAR) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (push) begin
            mem[ptr] <= din;
         end
      end
   end else begin : g_noclear
      always_ff @(posedge clk) begin
         if (push) mem[ptr] <= din;
      end
   end
endmodule

// File: rtl/pcseq_vecsel.sv
module pcseq_vecsel #(
   parameter int                      NSRC  = 4,
   parameter int                      OFS_W = 10,
   parameter int                      SRC_W = 2,
   parameter logic [NSRC*OFS_W-1:0]   TABLE = '0
) (
   input  logic [SRC_W-1:0] src,
   output logic [OFS_W-1:0] vec
);
   if (NSRC == 1) begin : g_single
      assign vec = TABLE[OFS_W-1:0];
   end else begin : g_multi
      logic [OFS_W-1:0] ent [NSRC];
      for (genvar i = 0; i < NSRC; i++) begin : g_ent
         assign ent[i] = TABLE[i*OFS_W +: OFS_W];
      end
      always_comb begin
         vec = ent[0];
         for (int i = 0; i < NSRC; i++) begin
            if (src == SRC_W'(i)) vec = ent[i];
         end
      end
   end
endmodule

// File: rtl/pcseq_ctx.sv
module pcseq_ctx #(
   parameter int DW   = 8,
   parameter int PG_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            save,
   input  logic            restore,
   input  logic [DW-1:0]   acc_in,
   input  logic [DW-1:0]   stat_in,
   input  logic [PG_W-1:0] page_in,
   output logic [DW-1:0]   sav_acc,
   output logic [DW-1:0]   sav_stat,
   output logic [PG_W-1:0] sav_page,
   output logic            valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sav_acc  <= '0;
         sav_stat <= '0;
         sav_page <= '0;
         valid    <= 1'b0;
      end else begin
         valid <= restore;
         if (save) begin
            sav_acc  <= acc_in;
            sav_stat <= stat_in;
            sav_page <= page_in;
         end
      end
   end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
   parameter int                     OFS_W       = 10,
   parameter int                     PG_W        = 3,
   parameter int                     DW          = 8,
   parameter int                     STACK_DEPTH = 8,
   parameter bit                     STACK_CLEAR = 1'b1,
   parameter int                     NSRC        = 4,
   parameter logic [NSRC*OFS_W-1:0]  VEC_TABLE   = {10'h00C, 10'h00A, 10'h008, 10'h006}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            op,
   input  logic [OFS_W-1:0]      target,
   input  logic [((NSRC > 1) ? $clog2(NSRC) : 1)-1:0] irq_src,
   input  logic                  page_we,
   input  logic [PG_W-1:0]       page_wd,
   input  logic [DW-1:0]         acc_in,
   input  logic [DW-1:0]         stat_in,
   output logic [PG_W+OFS_W-1:0] fetch_addr,
   output logic                  stall,
   output logic [DW-1:0]         ctx_acc,
   output logic [DW-1:0]         ctx_stat,
   output logic                  ctx_valid
);
   import pcseq_pkg::*;

   localparam int AW    = PG_W + OFS_W;
   localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   if (STACK_DEPTH < 2 || (STACK_DEPTH & (STACK_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("STACK_DEPTH must be a power of two and at least 2");
   end
   if (NSRC < 1) begin : g_bad_nsrc
      $error("NSRC must be at least 1");
   end
   if (OFS_W < 1 || PG_W < 1) begin : g_bad_width
      $error("OFS_W and PG_W must be positive");
   end

   pc_op_e            opc;
   logic              go;
   logic              flow;
   logic              push, pop, save, restore;
   logic [OFS_W-1:0]  ofs_q, ofs_d, push_val, stk_top, vec;
   logic [PG_W-1:0]   pg_q, pg_d, sav_page;
   logic              stall_q;

   assign opc = pc_op_e'(op);
   assign go  = !stall_q;

   always_comb begin
      ofs_d    = ofs_q;
      pg_d     = pg_q;
      push     = 1'b0;
      pop      = 1'b0;
      save     = 1'b0;
      restore  = 1'b0;
      flow     = 1'b0;
      push_val = ofs_q + OFS_W'(1);
      if (go) begin
         if (page_we) pg_d = page_wd;
         case (opc)
            OP_STEP: ofs_d = ofs_q + OFS_W'(1);
            OP_JUMP: begin
               ofs_d = target;
               flow  = 1'b1;
            end
            OP_CALL: begin
               push  = 1'b1;
               ofs_d = target;
               flow  = 1'b1;
            end
            OP_RET: begin
               pop   = 1'b1;
               ofs_d = stk_top;
               flow  = 1'b1;
            end
            OP_RETI: begin
               pop     = 1'b1;
               restore = 1'b1;
               ofs_d   = stk_top;
               pg_d    = sav_page;
               flow    = 1'b1;
            end
            OP_IRQ: begin
               push     = 1'b1;
               push_val = ofs_q;
               save     = 1'b1;
               ofs_d    = vec;
               pg_d     = '0;
               flow     = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q   <= '0;
         pg_q    <= '0;
         stall_q <= 1'b0;
      end else begin
         ofs_q   <= ofs_d;
         pg_q    <= pg_d;
         stall_q <= flow;
      end
   end

   pcseq_stack #(.W(OFS_W), .DEPTH(STACK_DEPTH), .CLEAR(STACK_CLEAR)) u_stack (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push),
      .pop  (pop),
      .din  (push_val),
      .top  (stk_top)
   );

   pcseq_vecsel #(.NSRC(NSRC), .OFS_W(OFS_W), .SRC_W(SRC_W), .TABLE(VEC_TABLE)) u_vec (
      .src(irq_src),
      .vec(vec)
   );

   pcseq_ctx #(.DW(DW), .PG_W(PG_W)) u_ctx (
      .clk     (clk),
      .rst_n   (rst_n),
      .save    (save),
      .restore (restore),
      .acc_in  (acc_in),
      .stat_in (stat_in),
      .page_in (pg_q),
      .sav_acc (ctx_acc),
      .sav_stat(ctx_stat),
      .sav_page(sav_page),
      .valid   (ctx_valid)
   );

   assign fetch_addr = {pg_q, ofs_q};
   assign stall      = stall_q;

   logic unused_aw;
   assign unused_aw = (AW == 0);
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
   parameter int OFS_W = 10,
   parameter int PG_W  = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [2:0]            op,
   input logic [OFS_W-1:0]      target,
   input logic                  page_we,
   input logic [PG_W+OFS_W-1:0] fetch_addr,
   input logic                  stall,
   input logic                  ctx_valid
);
   import pcseq_pkg::*;
   localparam int AW = PG_W + OFS_W;

   a_r2_step_incr: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && op == OP_STEP) |=>
         fetch_addr[OFS_W-1:0] == OFS_W'($past(fetch_addr[OFS_W-1:0]) + OFS_W'(1)));

   a_r3_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && op == OP_JUMP) |=> fetch_addr[OFS_W-1:0] == $past(target));

   a_r3_jump_page: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && op == OP_JUMP && !page_we) |=> $stable(fetch_addr[AW-1:OFS_W]));

   a_r7_stall_after_flow: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && op >= OP_JUMP && op <= OP_IRQ) |=> stall);

   a_r7_no_stall_linear: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && (op == OP_HOLD || op == OP_STEP || op == OP_RSVD)) |=> !stall);

   a_r7_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);

   a_r8_hold_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(fetch_addr));

   a_r9_irq_page0: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && op == OP_IRQ) |=> fetch_addr[AW-1:OFS_W] == '0);

   a_r10_ctx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_valid |-> $past(!stall && op == OP_RETI));

   a_r11_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && (op == OP_HOLD || op == OP_RSVD) && !page_we) |=> $stable(fetch_addr));
endmodule

bind pc_sequencer pcseq_chk #(.OFS_W(OFS_W), .PG_W(PG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op        (op),
   .target    (target),
   .page_we   (page_we),
   .fetch_addr(fetch_addr),
   .stall     (stall),
   .ctx_valid (ctx_valid)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [9:0]  target = '0;
   logic [1:0]  irq_src = '0;
   logic        page_we = 1'b0;
   logic [2:0]  page_wd = '0;
   logic [7:0]  acc_in = '0;
   logic [7:0]  stat_in = '0;
   logic [12:0] fetch_addr;
   logic        stall;
   logic [7:0]  ctx_acc, ctx_stat;
   logic        ctx_valid;

   always #4 clk = ~clk;

   pc_sequencer dut (
      .clk(clk), .rst_n(rst_n), .op(op), .target(target), .irq_src(irq_src),
      .page_we(page_we), .page_wd(page_wd), .acc_in(acc_in), .stat_in(stat_in),
      .fetch_addr(fetch_addr), .stall(stall), .ctx_acc(ctx_acc),
      .ctx_stat(ctx_stat), .ctx_valid(ctx_valid)
   );

   typedef struct {
      logic [12:0] addr;
      logic        stl;
      logic        cv;
      logic [7:0]  cacc;
      logic [7:0]  cstat;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;

   // reference model state
   logic [9:0] m_ofs = '0;
   logic [2:0] m_pg = '0;
   logic [9:0] m_stk [8];
   int         m_ptr = 0;
   logic       m_stall = 1'b0;
   logic [7:0] m_sacc = '0, m_sstat = '0;
   logic [2:0] m_spg = '0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [9:0] vec_of(logic [1:0] s);
      return 10'h006 + 10'(s) * 10'd2;
   endfunction

   task automatic cyc(input logic [2:0] o, input logic [9:0] t, input logic [1:0] s,
                      input logic pwe, input logic [2:0] pwd,
                      input logic [7:0] a, input logic [7:0] st, input string tag);
      exp_t e;
      logic flow;
      @(negedge clk);
      op = o; target = t; irq_src = s; page_we = pwe; page_wd = pwd;
      acc_in = a; stat_in = st;
      e.cv = 1'b0; e.cacc = m_sacc; e.cstat = m_sstat;
      flow = 1'b0;
      if (!m_stall) begin
         if (pwe && o != 3'd5 && o != 3'd6) m_pg = pwd;
         case (o)
            3'd1: m_ofs = m_ofs + 10'd1;
            3'd2: begin m_ofs = t; flow = 1'b1; end
            3'd3: begin
               m_stk[m_ptr] = m_ofs + 10'd1; m_ptr = (m_ptr + 1) % 8;
               m_ofs = t; flow = 1'b1;
            end
            3'd4: begin
               m_ptr = (m_ptr + 7) % 8; m_ofs = m_stk[m_ptr]; flow = 1'b1;
            end
            3'd5: begin
               m_ptr = (m_ptr + 7) % 8; m_ofs = m_stk[m_ptr];
               m_pg = m_spg; flow = 1'b1;
               e.cv = 1'b1; e.cacc = m_sacc; e.cstat = m_sstat;
            end
            3'd6: begin
               m_stk[m_ptr] = m_ofs; m_ptr = (m_ptr + 1) % 8;
               m_sacc = a; m_sstat = st; m_spg = m_pg;
               m_ofs = vec_of(s); m_pg = '0; flow = 1'b1;
            end
            default: ;
         endcase
      end
      m_stall = flow;
      e.addr = {m_pg, m_ofs};
      e.stl  = m_stall;
      e.tag  = tag;
      q.push_back(e);
   endtask

   task automatic idle(input string tag);
      cyc(3'd0, '0, '0, 1'b0, '0, '0, '0, tag);
   endtask

   // monitor: compare after each rising edge
   always @(posedge clk) begin
      exp_t e;
      #2;
      if (q.size() > 0) begin
         e = q.pop_front();
         check({e.tag, " addr"},  32'(fetch_addr), 32'(e.addr));
         check({e.tag, " stall"}, 32'(stall),      32'(e.stl));
         check({e.tag, " ctx_valid"}, 32'(ctx_valid), 32'(e.cv));
         if (e.cv) begin
            check({e.tag, " ctx_acc"},  32'(ctx_acc),  32'(e.cacc));
            check({e.tag, " ctx_stat"}, 32'(ctx_stat), 32'(e.cstat));
         end
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_stk[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 reset addr", 32'(fetch_addr), 32'h0);
      check("R1 reset stall", 32'(stall), 32'h0);
      check("R1 reset ctx_valid", 32'(ctx_valid), 32'h0);

      // R2 stepping, then R1/R6 pop from an empty stack yields cleared slot
      repeat (3) cyc(3'd1, '0, '0, 1'b0, '0, '0, '0, "R2 step");
      cyc(3'd4, '0, '0, 1'b0, '0, '0, '0, "R6 R1 pop empty");
      idle("R7 stall end");

      // R3 page write then jump, R2 offset wrap in page
      cyc(3'd0, '0, '0, 1'b1, 3'd5, '0, '0, "R11 R3 page write on hold");
      cyc(3'd2, 10'h3FE, '0, 1'b0, '0, '0, '0, "R3 jump keeps page");
      idle("R7 stall after jump");
      cyc(3'd1, '0, '0, 1'b0, '0, '0, '0, "R2 step");
      cyc(3'd1, '0, '0, 1'b0, '0, '0, '0, "R2 step wrap");
      cyc(3'd1, '0, '0, 1'b0, '0, '0, '0, "R2 step after wrap");
      cyc(3'd2, 10'h123, '0, 1'b1, 3'd2, '0, '0, "R3 jump with page write");
      idle("R7 stall");

      // R4 R5 eight nested calls
      for (int i = 0; i < 8; i++) begin
         cyc(3'd3, 10'(10'h040 + i * 10'h011), '0, 1'b0, '0, '0, '0, "R4 call nest");
         idle("R7 stall after call");
         cyc(3'd1, '0, '0, 1'b0, '0, '0, '0, "R2 step in sub");
      end
      for (int i = 0; i < 8; i++) begin
         cyc(3'd4, '0, '0, 1'b0, '0, '0, '0, "R5 return order");
         idle("R7 stall after ret");
      end

      // R6 overflow: nine pushes, nine pops
      for (int i = 0; i < 9; i++) begin
         cyc(3'd3, 10'(10'h200 + i * 10'h003), '0, 1'b0, '0, '0, '0, "R6 call overflow");
         idle("R7 stall");
      end
      for (int i = 0; i < 9; i++) begin
         cyc(3'd4, '0, '0, 1'b0, '0, '0, '0, "R6 ret after overflow");
         idle("R7 stall");
      end

      // R8 inputs ignored during stall
      cyc(3'd2, 10'h0AA, '0, 1'b0, '0, '0, '0, "R3 jump");
      cyc(3'd2, 10'h155, '0, 1'b1, 3'd7, '0, '0, "R8 ignored in stall");
      cyc(3'd1, '0, '0, 1'b0, '0, '0, '0, "R8 step after stall");
      cyc(3'd3, 10'h300, '0, 1'b0, '0, '0, '0, "R4 call");
      cyc(3'd4, '0, '0, 1'b1, 3'd1, '0, '0, "R8 ret ignored in stall");
      cyc(3'd4, '0, '0, 1'b0, '0, '0, '0, "R5 ret");
      idle("R7 stall");

      // R9 R10 interrupt entry, nested call inside handler, return
      cyc(3'd0, '0, '0, 1'b1, 3'd6, '0, '0, "R11 page write");
      cyc(3'd1, '0, '0, 1'b0, '0, '0, '0, "R2 step");
      cyc(3'd6, '0, 2'd2, 1'b1, 3'd3, 8'hA5, 8'h3C, "R9 irq src2");
      idle("R7 stall after irq");
      cyc(3'd1, '0, '0, 1'b0, '0, '0, '0, "R2 step in handler");
      cyc(3'd3, 10'h0F0, '0, 1'b0, '0, '0, '0, "R4 call in handler");
      idle("R7 stall");
      cyc(3'd4, '0, '0, 1'b0, '0, '0, '0, "R5 ret in handler");
      idle("R7 stall");
      cyc(3'd5, '0, '0, 1'b1, 3'd1, '0, '0, "R10 reti restores page");
      idle("R10 ctx pulse ends");
      cyc(3'd6, '0, 2'd3, 1'b0, '0, 8'h5A, 8'hC3, "R9 irq src3");
      idle("R7 stall");
      cyc(3'd6, '0, 2'd0, 1'b0, '0, 8'h11, 8'h22, "R9 irq src0 nested");
      idle("R7 stall");
      cyc(3'd5, '0, '0, 1'b0, '0, '0, '0, "R10 reti");
      idle("R10 ctx pulse ends");

      // R11 hold and reserved codes
      cyc(3'd0, '0, '0, 1'b0, '0, '0, '0, "R11 hold");
      cyc(3'd7, 10'h3FF, '0, 1'b0, '0, '0, '0, "R11 reserved code");
      cyc(3'd7, '0, '0, 1'b1, 3'd4, '0, '0, "R11 reserved with page write");

      idle("R11 tail");
      idle("R11 tail");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule